// File: doc/BRIEF.md
# Tile Control Register Slave

This block is a small APB slave occupying one 4 KB slot. It holds the control and status state of an expansion board: three clock-generator divisor settings guarded by a write key, an LED drive register, a latched push-button flag, a read-only view of the DIP switches, and the write-data, read-back and transfer-address registers used by a simple bus master elsewhere on the chip. The stored values are driven out as plain outputs so that the clock generators, LEDs, interrupt logic and bus master can use them directly.

The divisor registers change only after a 16-bit unlock key has been written to the key register. Any other key value locks them again. The reset value of the transfer address depends on a 2-bit board-detect input, so one build can serve more than one carrier board. The bus master's read result arrives as a valid-only stream. The block accepts a beat in every cycle and never applies back-pressure, so the stream has no ready signal. Each beat with the valid input high overwrites the read-back register.

Top module: `tile_ctrl_regs`

## Requirements
- R1: After reset the three divisor outputs are 0x30406, the LED output has all bits set, the button flag is 0, the write-data and read-back registers are 0, and the key register reads 0x10000 (locked, key field 0).
- R2: A write to a divisor register (byte offsets 0x00, 0x04, 0x08) while locked leaves the register unchanged. The block comes out of reset locked.
- R3: The key register is at offset 0x0C. Writing 0xA05F to bits 15:0 unlocks the divisors. Writing any other value relocks them. A read returns the stored key in bits 15:0 and, in bit 16, 1 when locked and 0 when unlocked.
- R4: While unlocked, a divisor write stores bits 18:0 of the write data as output-divider select in 18:16, VCO word in 15:9 and reference word in 8:0. Bits 31:19 are dropped and read as 0. The value appears on the output and is returned on reads.
- R5: Offset 0x10 holds the LED register, LED_W bits wide. It drives the LED output and reads back.
- R6: Offset 0x18 bit 0 is the button flag. It is set in any cycle where the button input is high. Writing 0 clears it, and writing 1 sets it. The button input wins over a clearing write in the same cycle. The flag drives the interrupt output.
- R7: Offset 0x1C returns the switch inputs in its low bits. Writes to it change nothing.
- R8: Offset 0x14 holds the master write data and drives it out. Offset 0x20 returns the last read-back beat captured when the valid input is high. Writes to 0x20 are ignored.
- R9: Offset 0x24 holds the transfer address, which is writable and driven out. On reset it loads 0x82000000 when board-detect is 00 and 0xC2000000 for any other value.
- R10: Reads of offsets not listed above (including anything at or above 0x28) return 0, and writes to them change no register. PREADY is always 1 and PSLVERR always 0.
- R11: A write takes effect at the clock edge that ends its access phase (PSEL, PENABLE and PWRITE high). Read data is valid during the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write flag |
| paddr | input | ADDR_W | APB byte address within the slot |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| board_id | input | 2 | Board-detect pins selecting the address default |
| button_i | input | 1 | Push-button level, high when pressed |
| dip_sw | input | LED_W | DIP switch levels |
| rdback_valid | input | 1 | Read-back beat valid (never back-pressured) |
| rdback_data | input | 32 | Read-back beat data |
| osc_div_o | output | 3*19 | Divisor settings, oscillator i in bits 19*i+18 : 19*i |
| led_o | output | LED_W | LED drive |
| button_irq_o | output | 1 | Latched button flag |
| mst_wdata_o | output | 32 | Master write data |
| mst_addr_o | output | 32 | Master transfer address |

## Verification
The divisor path is driven with writes in three states: before any key (fresh reset), after the correct key, and after a wrong key. This separates a register that ignores the lock from one that never unlocks or fails to relock. The button flag is exercised with a button pulse alone, a clearing write alone, a setting write, and a clearing write in the same cycle as a press, which pins down the priority. The address default is checked after resets with board-detect 00, 01 and 10, which tells a correct "any nonzero" rule from a test of one bit only. Read-only and unused offsets get writes followed by reads and output checks, to show that nothing was disturbed.

// File: rtl/tile_ctrl_pkg.sv
package tile_ctrl_pkg;
  localparam int          DIV_W      = 19;
  localparam int          OSC_N      = 3;
  localparam int          KEY_W      = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [DIV_W-1:0] DIV_RESET  = 19'h30406;

  // word index (byte offset / 4) of each register
  localparam logic [3:0] W_OSC0  = 4'd0;
  localparam logic [3:0] W_KEY   = 4'd3;
  localparam logic [3:0] W_LED   = 4'd4;
  localparam logic [3:0] W_WDATA = 4'd5;
  localparam logic [3:0] W_BTN   = 4'd6;
  localparam logic [3:0] W_SW    = 4'd7;
  localparam logic [3:0] W_RDBK  = 4'd8;
  localparam logic [3:0] W_XADDR = 4'd9;
  localparam logic [3:0] W_LAST  = W_XADDR;
endpackage

// File: rtl/tile_ctrl_decode.sv
module tile_ctrl_decode
  import tile_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              hit,
  output logic [3:0]        widx,
  output logic              wr_en
);
  localparam int HI_W = ADDR_W - 6;

  always_comb begin
    widx  = paddr[5:2];
    hit   = (paddr[ADDR_W-1:6] == HI_W'(0)) && (widx <= W_LAST);
    wr_en = psel && penable && pwrite && hit;
  end
endmodule

// File: rtl/tile_ctrl_osc_bank.sv
module tile_ctrl_osc_bank
  import tile_ctrl_pkg::*;
#(
  parameter int N = OSC_N,
  parameter int W = DIV_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         wr_hit,
  input  logic [W-1:0]         wdata,
  input  logic                 key_wr,
  input  logic [KEY_W-1:0]     key_data,
  output logic [N*W-1:0]       div_q,
  output logic [KEY_W-1:0]     key_q,
  output logic                 locked_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      key_q <= '0;
    else if (key_wr) key_q <= key_data;
  end

  assign locked_o = (key_q != UNLOCK_KEY);

  for (genvar i = 0; i < N; i++) begin : g_osc
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                     r <= DIV_RESET;
      else if (wr_hit[i] && !locked_o) r <= wdata;
    end
    assign div_q[i*W +: W] = r;

    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && locked_o) |=> $stable(div_q[i*W +: W]));
    assert_unlocked_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && !locked_o) |=> (div_q[i*W +: W] == $past(wdata)));
  end

  assert_key_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == UNLOCK_KEY) |=> !locked_o);
  assert_key_relocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != UNLOCK_KEY) |=> locked_o);
endmodule

// File: rtl/tile_ctrl_btn_flag.sv
module tile_ctrl_btn_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic button_i,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (button_i) flag_o <= 1'b1;
    else if (wr_en)    flag_o <= wr_bit;
  end

  assert_press_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    button_i |=> flag_o);
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit && !button_i) |=> !flag_o);
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !button_i) |=> $stable(flag_o));
endmodule

// File: rtl/tile_ctrl_regs.sv
module tile_ctrl_regs
  import tile_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          LED_W     = 8,
  parameter logic [31:0] XADDR_DEF0 = 32'h8200_0000,
  parameter logic [31:0] XADDR_DEF1 = 32'hC200_0000
) (
  input  logic                   pclk,
  input  logic                   presetn,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [31:0]            pwdata,
  output logic [31:0]            prdata,
  output logic                   pready,
  output logic                   pslverr,
  input  logic [1:0]             board_id,
  input  logic                   button_i,
  input  logic [LED_W-1:0]       dip_sw,
  input  logic                   rdback_valid,
  input  logic [31:0]            rdback_data,
  output logic [OSC_N*DIV_W-1:0] osc_div_o,
  output logic [LED_W-1:0]       led_o,
  output logic                   button_irq_o,
  output logic [31:0]            mst_wdata_o,
  output logic [31:0]            mst_addr_o
);
  logic             hit;
  logic [3:0]       widx;
  logic             wr_en;
  logic [OSC_N-1:0] osc_wr;
  logic [KEY_W-1:0] key_q;
  logic             locked;
  logic [31:0]      rdback_q;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tile_ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .hit(hit), .widx(widx), .wr_en(wr_en)
  );

  for (genvar i = 0; i < OSC_N; i++) begin : g_oscsel
    assign osc_wr[i] = wr_en && (widx == W_OSC0 + 4'(i));
  end

  tile_ctrl_osc_bank #(.N(OSC_N), .W(DIV_W)) u_osc (
    .clk(pclk), .rst_n(presetn), .wr_hit(osc_wr), .wdata(pwdata[DIV_W-1:0]),
    .key_wr(wr_en && widx == W_KEY), .key_data(pwdata[KEY_W-1:0]),
    .div_q(osc_div_o), .key_q(key_q), .locked_o(locked)
  );

  tile_ctrl_btn_flag u_btn (
    .clk(pclk), .rst_n(presetn), .button_i(button_i),
    .wr_en(wr_en && widx == W_BTN), .wr_bit(pwdata[0]), .flag_o(button_irq_o)
  );

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      led_o       <= '1;
      mst_wdata_o <= '0;
      mst_addr_o  <= (board_id == 2'b00) ? XADDR_DEF0 : XADDR_DEF1;
      rdback_q    <= '0;
    end else begin
      if (wr_en && widx == W_LED)   led_o       <= pwdata[LED_W-1:0];
      if (wr_en && widx == W_WDATA) mst_wdata_o <= pwdata;
      if (wr_en && widx == W_XADDR) mst_addr_o  <= pwdata;
      if (rdback_valid)             rdback_q    <= rdback_data;
    end
  end

  always_comb begin
    prdata = '0;
    if (hit) begin
      case (widx)
        W_KEY:   prdata = {15'd0, locked, key_q};
        W_LED:   prdata = 32'(led_o);
        W_WDATA: prdata = mst_wdata_o;
        W_BTN:   prdata = {31'd0, button_irq_o};
        W_SW:    prdata = 32'(dip_sw);
        W_RDBK:  prdata = rdback_q;
        W_XADDR: prdata = mst_addr_o;
        default: begin
          for (int i = 0; i < OSC_N; i++)
            if (widx == W_OSC0 + 4'(i)) prdata = 32'(osc_div_o[i*DIV_W +: DIV_W]);
        end
      endcase
    end
  end

  assert_rdback_capture_R8: assert property (@(posedge pclk) disable iff (!presetn)
    rdback_valid |=> (rdback_q == $past(rdback_data)));
  assert_led_write_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == ADDR_W'(32'h10)) |=> (led_o == $past(pwdata[LED_W-1:0])));
  assert_unused_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && paddr >= ADDR_W'(32'h28)) |-> (prdata == 32'd0));
  assert_addr_hold_R9: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && pwrite && paddr[ADDR_W-1:2] == (ADDR_W-2)'(9)) |=> $stable(mst_addr_o));
endmodule

// File: tb/tile_ctrl_regs_tb.sv
module tile_ctrl_regs_tb;
  localparam int LED_W = 8;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  board_id = 2'b00;
  logic        button_i = 1'b0;
  logic [LED_W-1:0] dip_sw = 8'hA5;
  logic        rdback_valid = 1'b0;
  logic [31:0] rdback_data = '0;
  logic [56:0] osc_div_o;
  logic [LED_W-1:0] led_o;
  logic        button_irq_o;
  logic [31:0] mst_wdata_o, mst_addr_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #4 pclk = ~pclk;

  tile_ctrl_regs #(.LED_W(LED_W)) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .board_id(board_id), .button_i(button_i), .dip_sw(dip_sw),
    .rdback_valid(rdback_valid), .rdback_data(rdback_data),
    .osc_div_o(osc_div_o), .led_o(led_o), .button_irq_o(button_irq_o),
    .mst_wdata_o(mst_wdata_o), .mst_addr_o(mst_addr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] bid);
    @(negedge pclk);
    presetn = 1'b0; board_id = bid;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    check("R10 pready", {31'd0, pready}, 32'd1);
    check("R10 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset_values;
    check("R1 osc0", 32'(osc_div_o[18:0]), 32'h30406);
    check("R1 osc1", 32'(osc_div_o[37:19]), 32'h30406);
    check("R1 osc2", 32'(osc_div_o[56:38]), 32'h30406);
    check("R1 led", 32'(led_o), 32'hFF);
    check("R1 irq", {31'd0, button_irq_o}, 32'd0);
    check("R1 wdata", mst_wdata_o, 32'd0);
    apb_rd(12'h0C, rd); check("R1 key reg", rd, 32'h0001_0000);
    apb_rd(12'h20, rd); check("R1 rdback", rd, 32'd0);
    check("R9 default board 00", mst_addr_o, 32'h8200_0000);
  endtask

  task automatic t_lock;
    apb_wr(12'h04, 32'h0001_2345);
    check("R2 locked write osc1", 32'(osc_div_o[37:19]), 32'h30406);
    apb_wr(12'h0C, 32'h0000_A05F);
    apb_rd(12'h0C, rd); check("R3 unlocked read", rd, 32'h0000_A05F);
    apb_wr(12'h04, 32'hFFF1_2345);
    check("R4 osc1 stored", 32'(osc_div_o[37:19]), 32'h1_2345);
    apb_rd(12'h04, rd); check("R4 osc1 readback", rd, 32'h0001_2345);
    apb_wr(12'h08, 32'h0007_FFFF);
    check("R4 osc2 fields", 32'(osc_div_o[56:38]), 32'h7_FFFF);
    check("R4 osc0 untouched", 32'(osc_div_o[18:0]), 32'h30406);
    apb_wr(12'h0C, 32'h0000_A05E);
    apb_rd(12'h0C, rd); check("R3 relocked read", rd, 32'h0001_A05E);
    apb_wr(12'h00, 32'h0000_0001);
    check("R2 relocked write osc0", 32'(osc_div_o[18:0]), 32'h30406);
  endtask

  task automatic t_leds;
    apb_wr(12'h10, 32'hFFFF_FF03);
    check("R5 led out", 32'(led_o), 32'h03);
    apb_rd(12'h10, rd); check("R5 led read", rd, 32'h03);
  endtask

  task automatic t_button;
    @(negedge pclk); button_i = 1'b1;
    @(negedge pclk); button_i = 1'b0;
    check("R6 press sets", {31'd0, button_irq_o}, 32'd1);
    apb_rd(12'h18, rd); check("R6 flag read", rd, 32'd1);
    apb_wr(12'h18, 32'd0);
    check("R6 write 0 clears", {31'd0, button_irq_o}, 32'd0);
    apb_wr(12'h18, 32'd1);
    check("R6 write 1 sets", {31'd0, button_irq_o}, 32'd1);
    apb_wr(12'h18, 32'd0);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h18; pwdata = 32'd0;
    @(negedge pclk);
    penable = 1'b1; button_i = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; button_i = 1'b0;
    check("R6 press beats clear", {31'd0, button_irq_o}, 32'd1);
  endtask

  task automatic t_switch;
    apb_rd(12'h1C, rd); check("R7 switch read", rd, 32'hA5);
    dip_sw = 8'h3C;
    apb_wr(12'h1C, 32'hFFFF_FFFF);
    apb_rd(12'h1C, rd); check("R7 switch after write", rd, 32'h3C);
  endtask

  task automatic t_master;
    apb_wr(12'h14, 32'h1234_5678);
    check("R8 wdata out", mst_wdata_o, 32'h1234_5678);
    @(negedge pclk); rdback_valid = 1'b1; rdback_data = 32'hCAFE_F00D;
    @(negedge pclk); rdback_valid = 1'b0; rdback_data = 32'h0;
    apb_rd(12'h20, rd); check("R8 rdback capture", rd, 32'hCAFE_F00D);
    apb_wr(12'h20, 32'h1111_1111);
    apb_rd(12'h20, rd); check("R8 rdback read-only", rd, 32'hCAFE_F00D);
    apb_wr(12'h24, 32'h8400_0010);
    check("R9 addr write", mst_addr_o, 32'h8400_0010);
    apb_rd(12'h24, rd); check("R11 addr read", rd, 32'h8400_0010);
  endtask

  task automatic t_unused;
    apb_wr(12'h28, 32'hFFFF_FFFF);
    apb_wr(12'h40, 32'hFFFF_FFFF);
    apb_rd(12'h28, rd); check("R10 unused 0x28", rd, 32'd0);
    apb_rd(12'h3C, rd); check("R10 unused 0x3C", rd, 32'd0);
    apb_rd(12'h400, rd); check("R10 unused 0x400", rd, 32'd0);
    check("R10 led unchanged", 32'(led_o), 32'h03);
    check("R10 addr unchanged", mst_addr_o, 32'h8400_0010);
    check("R10 wdata unchanged", mst_wdata_o, 32'h1234_5678);
  endtask

  task automatic t_board;
    do_reset(2'b01);
    check("R9 default board 01", mst_addr_o, 32'hC200_0000);
    do_reset(2'b10);
    check("R9 default board 10", mst_addr_o, 32'hC200_0000);
    check("R1 led after re-reset", 32'(led_o), 32'hFF);
  endtask

  initial begin
    do_reset(2'b00);
    t_reset_values();
    t_lock();
    t_leds();
    t_button();
    t_switch();
    t_master();
    t_unused();
    t_board();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge pclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule